// File: doc/BRIEF.md
# Audio Codec Register Initialisation Sequencer

This block brings a stereo audio codec from its power-on state to a playing state without any processor help. After reset it waits for a start pulse. It then walks a fixed list of codec register writes, sending each one as a single I2C write transaction. Pauses of at least one millisecond are placed after the writes that need settling time. When the last write's stop condition has finished, a done flag rises and stays high.

The bus side is a small write-only I2C master. It has no read path, no arbitration and no clock stretching. Both bus wires are open-drain. The block only ever pulls a wire low, through an output-enable, and lets the external pull-up raise it. The SDA level is sensed so that the acknowledge bit can be checked. If the codec fails to acknowledge, the transaction ends with a stop, the script halts and an error flag is raised instead of done.

Bus speed and pause length come from parameters. By default SCL runs at about 100 kHz from a 50 MHz clock, and a pause is one millisecond plus one cycle.

Top module: `codec_init_seq`

## Requirements
- R1: The first byte after every start condition is 0x34: device address 0x1A in bits 7:1 and a write bit of 0 in bit 0. Exactly two data bytes follow it.
- R2: Each codec write packs its 9-bit value and 7-bit register number into two bytes. The first data byte holds the register number in bits 7:1 and value bit 8 in bit 0. The second data byte holds value bits 7:0.
- R3: The writes go out in this order as (register, value): (15,0x000), (6,0x070), (2,0x179), (3,0x179), (4,0x000), (5,0x000), (7,0x001), (8,0x000), (9,0x001), (6,0x020), (4,0x016).
- R4: A quiet gap of at least PAUSE_CYCLES clock cycles separates the stop of a write from the next start after the writes to register 15, register 8, register 9 and the second write to register 6. Every other gap is shorter than PAUSE_CYCLES. Both lines are released during a pause.
- R5: Each write is framed by one start condition (SDA falls while SCL is high) and one stop condition (SDA rises while SCL is high). Inside a frame SDA changes only while SCL is low. SCL and SDA never change in the same cycle.
- R6: done is low while the final stop condition forms. It rises after that stop and stays high, with both lines released, until reset.
- R7: If SDA is sampled high in an acknowledge slot, the master sends a stop and raises error. No further write is started and done never rises. done and error are never high together.
- R8: The block issues no bus activity until start. A start pulse during a run, or after done, is ignored.
- R9: During and right after reset, done and error are low and both line enables are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin the initialisation script |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | Script finished, held until reset |
| error | output | 1 | Script aborted on a missing acknowledge, held until reset |

## Verification
Bus results are not due on a fixed cycle. Each transaction lasts a number of quarter-SCL ticks, so the bench decodes the wires on every falling clock edge and records bytes, conditions and gap lengths against the cycle count. done is due between one and two ticks after the final stop condition. For that reason the bench records done at the cycle the stop is seen (expected low) and checks it again once the run has settled. After an injected NACK the error flag must appear within a bounded polling window. The bench then watches several hundred more cycles to confirm that no new start occurs.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

    localparam int          SCRIPT_LEN = 11;
    localparam int          FRAME_BITS = 27;
    localparam logic [6:0]  DEV_ADDR   = 7'h1A;

    typedef struct packed {
        logic [6:0] reg_num;
        logic [8:0] value;
        logic       hold_after;
    } cfg_step_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_PAUSE, SQ_DONE, SQ_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        BM_IDLE, BM_START, BM_BITS, BM_STOP
    } bus_state_t;

    // Power-up order; hold_after marks writes that need settling time.
    function automatic cfg_step_t script_step(input logic [3:0] idx);
        cfg_step_t s;
        case (idx)
            4'd0:    s = '{reg_num: 7'd15, value: 9'h000, hold_after: 1'b1};
            4'd1:    s = '{reg_num: 7'd6,  value: 9'h070, hold_after: 1'b0};
            4'd2:    s = '{reg_num: 7'd2,  value: 9'h179, hold_after: 1'b0};
            4'd3:    s = '{reg_num: 7'd3,  value: 9'h179, hold_after: 1'b0};
            4'd4:    s = '{reg_num: 7'd4,  value: 9'h000, hold_after: 1'b0};
            4'd5:    s = '{reg_num: 7'd5,  value: 9'h000, hold_after: 1'b0};
            4'd6:    s = '{reg_num: 7'd7,  value: 9'h001, hold_after: 1'b0};
            4'd7:    s = '{reg_num: 7'd8,  value: 9'h000, hold_after: 1'b1};
            4'd8:    s = '{reg_num: 7'd9,  value: 9'h001, hold_after: 1'b1};
            4'd9:    s = '{reg_num: 7'd6,  value: 9'h020, hold_after: 1'b1};
            default: s = '{reg_num: 7'd4,  value: 9'h016, hold_after: 1'b0};
        endcase
        return s;
    endfunction

    // Serial image of one write; each '1' after a byte is a released ACK slot.
    function automatic logic [FRAME_BITS-1:0] pack_frame(input cfg_step_t s);
        return {DEV_ADDR, 1'b0, 1'b1,
                s.reg_num, s.value[8], 1'b1,
                s.value[7:0], 1'b1};
    endfunction

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || cnt == CW'(DIV - 1)) cnt <= '0;
                else                            cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/i2c_frame_tx.sv
module i2c_frame_tx
    import codec_init_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  sda_in,
    output logic                  scl_oe,
    output logic                  sda_oe,
    output logic                  fin,
    output logic                  nack
);
    localparam int BW = $clog2(FRAME_BITS);

    bus_state_t            state;
    logic [1:0]            q;
    logic [BW-1:0]         bidx;
    logic [FRAME_BITS-1:0] sh;
    logic                  ack_slot;

    assign ack_slot = (bidx == BW'(8)) || (bidx == BW'(17)) || (bidx == BW'(26));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BM_IDLE;
            q      <= '0;
            bidx   <= '0;
            sh     <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            fin    <= 1'b0;
            nack   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (state)
                BM_IDLE: if (go) begin
                    sh    <= frame;
                    nack  <= 1'b0;
                    q     <= '0;
                    state <= BM_START;
                end
                BM_START: if (tick) begin
                    case (q)
                        2'd1:    sda_oe <= 1'b1;
                        2'd2:    scl_oe <= 1'b1;
                        default: ;
                    endcase
                    if (q == 2'd2) begin
                        q     <= '0;
                        bidx  <= '0;
                        state <= BM_BITS;
                    end else begin
                        q <= q + 1'b1;
                    end
                end
                BM_BITS: if (tick) begin
                    q <= q + 1'b1;
                    case (q)
                        2'd0: sda_oe <= ~sh[FRAME_BITS-1];
                        2'd1: scl_oe <= 1'b0;
                        2'd2: if (ack_slot && sda_in) nack <= 1'b1;
                        default: begin
                            scl_oe <= 1'b1;
                            sh     <= {sh[FRAME_BITS-2:0], 1'b0};
                            if (bidx == BW'(FRAME_BITS - 1) || (ack_slot && nack))
                                state <= BM_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end
                    endcase
                end
                default: if (tick) begin   // BM_STOP
                    q <= q + 1'b1;
                    case (q)
                        2'd0: sda_oe <= 1'b1;
                        2'd1: scl_oe <= 1'b0;
                        2'd2: sda_oe <= 1'b0;
                        default: begin
                            fin   <= 1'b1;
                            state <= BM_IDLE;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
    parameter int CYCLES = 50001
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt;
    logic         active;

    assign expired = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= W'(CYCLES - 1);
            active <= 1'b1;
        end else if (expired) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int SCL_HZ       = 100_000,
    parameter int PAUSE_CYCLES = CLK_HZ / 1000 + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic done,
    output logic error
);
    localparam int QDIV = (CLK_HZ / (4 * SCL_HZ) < 1) ? 1 : CLK_HZ / (4 * SCL_HZ);
    localparam logic [3:0] LAST_IDX = 4'(SCRIPT_LEN - 1);

    seq_state_t sq_state;
    logic [3:0] step_idx;
    cfg_step_t  cur_step;
    logic       tick, go, fin, nack, pause_load, pause_done;
    logic       pause_run, seq_busy;

    assign cur_step   = script_step(step_idx);
    assign go         = (sq_state == SQ_ISSUE);
    assign pause_load = (sq_state == SQ_WAIT) && fin && !nack && cur_step.hold_after;
    assign pause_run  = (sq_state == SQ_PAUSE);
    assign seq_busy   = (sq_state != SQ_IDLE);
    assign done       = (sq_state == SQ_DONE);
    assign error      = (sq_state == SQ_FAIL);

    i2c_quarter_tick #(.DIV(QDIV)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    i2c_frame_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .go     (go),
        .frame  (pack_frame(cur_step)),
        .sda_in (sda_in),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .fin    (fin),
        .nack   (nack)
    );

    pause_timer #(.CYCLES(PAUSE_CYCLES)) u_pause (
        .clk (clk), .rst (rst), .load (pause_load), .expired (pause_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_state <= SQ_IDLE;
            step_idx <= '0;
        end else begin
            case (sq_state)
                SQ_IDLE: if (start) begin
                    step_idx <= '0;
                    sq_state <= SQ_ISSUE;
                end
                SQ_ISSUE: sq_state <= SQ_WAIT;
                SQ_WAIT: if (fin) begin
                    if (nack)                     sq_state <= SQ_FAIL;
                    else if (cur_step.hold_after) sq_state <= SQ_PAUSE;
                    else if (step_idx == LAST_IDX) sq_state <= SQ_DONE;
                    else begin
                        step_idx <= step_idx + 1'b1;
                        sq_state <= SQ_ISSUE;
                    end
                end
                SQ_PAUSE: if (pause_done) begin
                    if (step_idx == LAST_IDX) sq_state <= SQ_DONE;
                    else begin
                        step_idx <= step_idx + 1'b1;
                        sq_state <= SQ_ISSUE;
                    end
                end
                default: ;   // SQ_DONE and SQ_FAIL hold until reset
            endcase
        end
    end
endmodule

// File: rtl/codec_init_chk.sv
module codec_init_chk (
    input logic clk,
    input logic rst,
    input logic scl_oe,
    input logic sda_oe,
    input logic done,
    input logic error,
    input logic pause_run,
    input logic seq_busy
);
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        done |=> done);                                            // R6
    AST_DONE_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scl_oe && !sda_oe));                            // R6
    AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        error |=> (error && !done));                               // R7
    AST_NOT_DONE_AND_ERROR: assert property (@(posedge clk) disable iff (rst)
        !(done && error));                                         // R7
    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        pause_run |-> (!scl_oe && !sda_oe));                       // R4
    AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !((scl_oe != $past(scl_oe)) && (sda_oe != $past(sda_oe)))); // R5
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> (!scl_oe && !sda_oe));                       // R8
endmodule

bind codec_init_seq codec_init_chk u_codec_init_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .done      (done),
    .error     (error),
    .pause_run (pause_run),
    .seq_busy  (seq_busy)
);

// File: tb/test_codec_init_seq.sv
module test_codec_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE_CYC  = 300;
    localparam int NWR        = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic scl_oe, sda_oe, done, error;
    logic ack_drv = 1'b0;
    logic sda_in;

    assign sda_in = ~(sda_oe | ack_drv);

    always #(CLK_PERIOD / 2) clk = ~clk;

    codec_init_seq #(
        .CLK_HZ(4_000_000), .SCL_HZ(500_000), .PAUSE_CYCLES(PAUSE_CYC)
    ) i_codec_init_seq (
        .clk(clk), .rst(rst), .start(start), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .error(error)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // ---------------- bus slave model ----------------
    int       cyc = 0, n_start = 0, n_stop = 0, last_stop = 0, txn = 0;
    int       bitcnt = 0, bytecnt = 0;
    logic     p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] shin = '0;
    logic [7:0] rx   [0:15][0:2];
    int       gap    [0:15];
    int       nbytes [0:15];
    logic     done_at_stop [0:15];
    logic     nack_armed = 1'b0;
    int       nk = 0, nb = 0;

    always @(negedge clk) begin
        logic scl_now, sda_now;
        cyc++;
        scl_now = ~scl_oe;
        sda_now = ~(sda_oe | ack_drv);
        if (scl_now && p_scl && p_sda && !sda_now) begin
            txn = n_start;
            if (txn < 16) gap[txn] = cyc - last_stop;
            n_start++;
            bitcnt = 0; bytecnt = 0;
        end else if (scl_now && p_scl && !p_sda && sda_now) begin
            if (txn < 16) begin
                nbytes[txn]       = bytecnt;
                done_at_stop[txn] = done;
            end
            n_stop++;
            last_stop = cyc;
        end else if (scl_now && !p_scl) begin
            if (bitcnt < 8) shin = {shin[6:0], sda_now};
            bitcnt++;
        end else if (!scl_now && p_scl) begin
            if (bitcnt == 8) begin
                if (txn < 16 && bytecnt < 3) rx[txn][bytecnt] = shin;
                ack_drv = !(nack_armed && txn == nk && bytecnt == nb);
                bytecnt++;
            end else if (bitcnt == 9) begin
                ack_drv = 1'b0;
                bitcnt  = 0;
            end
        end
        p_scl = scl_now;
        p_sda = ~(sda_oe | ack_drv);
    end

    // ---------------- expected script ----------------
    function automatic int exp_reg(input int k);
        int r [0:10] = '{15, 6, 2, 3, 4, 5, 7, 8, 9, 6, 4};
        return r[k];
    endfunction
    function automatic int exp_val(input int k);
        int v [0:10] = '{0, 'h70, 'h179, 'h179, 0, 0, 1, 0, 1, 'h20, 'h16};
        return v[k];
    endfunction
    function automatic bit exp_hold(input int k);
        return (k == 0) || (k == 7) || (k == 8) || (k == 9);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        n_start = 0; n_stop = 0; txn = 0; last_stop = cyc;
        bitcnt = 0; bytecnt = 0; ack_drv = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 30000; i++) begin
            if (done || error) break;
            @(negedge clk);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int r, busy_wait;
        r = $urandom(32'd2024);
        repeat (2) @(negedge clk);
        // R9: reset values
        check(!done && !error, "R9 flags in reset", {done, error}, 0);
        check(!scl_oe && !sda_oe, "R9 lines in reset", {scl_oe, sda_oe}, 0);
        do_reset();
        check(!done && !error && !scl_oe && !sda_oe, "R9 after reset",
              {done, error, scl_oe, sda_oe}, 0);

        // R8: silent until start
        repeat (40 + $urandom_range(40, 0)) @(negedge clk);
        check(n_start == 0, "R8 no activity before start", n_start, 0);

        // full run with an extra start pulse mid-way (R8)
        pulse_start();
        busy_wait = $urandom_range(1500, 100);
        repeat (busy_wait) @(negedge clk);
        pulse_start();
        wait_end();
        repeat (20) @(negedge clk);

        check(done && !error, "R6 done after run", {done, error}, 2);
        check(n_start == NWR, "R5 start count", n_start, NWR);
        check(n_stop == NWR, "R5 stop count", n_stop, NWR);
        for (int k = 0; k < NWR; k++) begin
            int v;
            v = exp_val(k);
            check(nbytes[k] == 3, "R1 byte count", nbytes[k], 3);
            check(rx[k][0] == 8'h34, "R1 address byte", rx[k][0], 'h34);
            check(rx[k][1] == 8'((exp_reg(k) << 1) | ((v >> 8) & 1)),
                  "R2/R3 first data byte", rx[k][1], (exp_reg(k) << 1) | ((v >> 8) & 1));
            check(rx[k][2] == 8'(v & 8'hFF), "R2/R3 second data byte", rx[k][2], v & 8'hFF);
            if (k > 0) begin
                if (exp_hold(k - 1))
                    check(gap[k] >= PAUSE_CYC, "R4 pause present", gap[k], PAUSE_CYC);
                else
                    check(gap[k] < PAUSE_CYC, "R4 no pause", gap[k], PAUSE_CYC);
            end
        end
        check(done_at_stop[NWR-1] == 1'b0, "R6 done low at final stop",
              done_at_stop[NWR-1], 0);

        // R6/R8: start after done ignored, done holds
        pulse_start();
        repeat (300) @(negedge clk);
        check(n_start == NWR, "R8 start after done ignored", n_start, NWR);
        check(done && !scl_oe && !sda_oe, "R6 done holds, lines free",
              {done, scl_oe, sda_oe}, 4);

        // R7: NACK injection trials (directed corners plus random)
        for (int t = 0; t < 4; t++) begin
            case (t)
                0: begin nk = 0;  nb = 0; end
                1: begin nk = 10; nb = 2; end
                default: begin nk = $urandom_range(10, 0); nb = $urandom_range(2, 0); end
            endcase
            nack_armed = 1'b1;
            do_reset();
            check(!done && !error, "R9 clear after reset", {done, error}, 0);
            pulse_start();
            wait_end();
            repeat (10) @(negedge clk);
            check(error && !done, "R7 error raised", {error, done}, 2);
            check(n_start == nk + 1, "R7 halted after nack", n_start, nk + 1);
            check(n_stop == n_start, "R7 stop issued", n_stop, n_start);
            check(nbytes[nk] == nb + 1, "R7 abort point", nbytes[nk], nb + 1);
            repeat (PAUSE_CYC + 200) @(negedge clk);
            check(n_start == nk + 1 && !done && error && !scl_oe && !sda_oe,
                  "R7 stays halted", n_start, nk + 1);
            nack_armed = 1'b0;
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule